// File: doc/BRIEF.md
# Stage-Dependent Gate Trigger Router

This block sits between the trigger timing logic and the switching supplies of five induction cells. Two timing sources each deliver strobes that mark where a SET gate pulse starts and ends, and where a RESET gate pulse starts and ends. The block turns every start/end pair into a level with a small stretcher. It then decides, from the active acceleration stage and the turn count, which cells receive those levels.

The stage arrives as four one-hot levels. Stage I fires cells 1 and 2 in series, one cell per timing source. Stage II fires cells 1 to 3 together from source 1. Stages III and IV fire the cells intermittently. In these stages a round-robin counter, advanced by the synchronised bunch (revolution) pulse, picks a cell group for each turn. Stage III divides the turns by two and Stage IV by three. As a result, no cell is triggered on every turn.

When no stage level is high, or the stage input is not one-hot, the block treats this as the transition guard. Nothing reaches any cell during the guard, and the stretchers are cleared.

Top module: `gate_trigger_router`

## Requirements
- R1: Each stretcher level goes high on the clock after its start strobe. It stays high until its end strobe and goes low on the clock after that end strobe.
- R2: When a start strobe and an end strobe of the same stretcher arrive in the same cycle, the level ends up low.
- R3: In Stage I (stage_i = 4'b0001), source 1 levels drive cell 1 (bit 0) and source 2 levels drive cell 2 (bit 1). Cells 3 to 5 stay low.
- R4: In Stage II (stage_i = 4'b0010), source 1 levels drive cells 1, 2 and 3 (bits 0 to 2) at the same time. Source 2 has no effect, and cells 4 and 5 stay low.
- R5: In Stage III (stage_i = 4'b0100), source 1 levels alternate on each bunch turn between group N, cells 1 and 4 (5'b01001), and group N+1, cells 2 and 5 (5'b10010).
- R6: In Stage IV (stage_i = 4'b1000), source 1 levels rotate on each bunch turn through three groups: cells 1 and 4 (5'b01001), then cells 2 and 5 (5'b10010), then cells 3 and 5 (5'b10100 by default). The order then repeats.
- R7: While stage_i is zero or has more than one bit set, every cell SET and RESET output is low. Every stretcher is cleared and ignores its start strobes.
- R8: When the stage input changes, the round-robin restarts at group N (cells 1 and 4), starting from the first routed clock of the new stage.
- R9: The round-robin advances once per rising edge of the synchronised bunch pulse. A bunch pulse held high for many cycles advances it only once.
- R10: Cell outputs are registered. A start strobe shows on a cell output two clocks after it is sampled: one clock in the stretcher and one in the output register.
- R11: During and right after reset, all cell outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bunch_in | input | 1 | Bunch (revolution) pulse, asynchronous |
| stage_i | input | 4 | One-hot stage levels, bit 0 = Stage I |
| s1_set_start | input | 1 | Source 1 SET start strobe |
| s1_set_end | input | 1 | Source 1 SET end strobe |
| s1_rst_start | input | 1 | Source 1 RESET start strobe |
| s1_rst_end | input | 1 | Source 1 RESET end strobe |
| s2_set_start | input | 1 | Source 2 SET start strobe |
| s2_set_end | input | 1 | Source 2 SET end strobe |
| s2_rst_start | input | 1 | Source 2 RESET start strobe |
| s2_rst_end | input | 1 | Source 2 RESET end strobe |
| cell_set | output | 5 | SET enable per cell, bit 0 = cell 1 |
| cell_rst | output | 5 | RESET enable per cell, bit 0 = cell 1 |

## Verification
The strobes are applied one source and one direction at a time in each stage, so that a mis-wired cell or a swapped source shows up as a wrong bit. Simultaneous start/end strobes and strobes given during the guard test the stretcher's priority and clearing. Each round-robin sequence is checked with several bunch turns in Stages III and IV, and each sequence starts by entering the stage from another stage, so that the restart to group N is checked. A bunch pulse held high over many cycles tells edge-based advancing apart from level-based advancing. A cycle-exact probe after a strobe shows the two-register latency.

// File: rtl/gate_trigger_router.sv
module gate_trigger_router #(
  parameter int SYNC_LEN = 2,
  parameter logic [4:0] GRP_N  = 5'b01001,
  parameter logic [4:0] GRP_N1 = 5'b10010,
  parameter logic [4:0] GRP_N2 = 5'b10100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bunch_in,
  input  logic [3:0] stage_i,
  input  logic       s1_set_start,
  input  logic       s1_set_end,
  input  logic       s1_rst_start,
  input  logic       s1_rst_end,
  input  logic       s2_set_start,
  input  logic       s2_set_end,
  input  logic       s2_rst_start,
  input  logic       s2_rst_end,
  output logic [4:0] cell_set,
  output logic [4:0] cell_rst
);
  localparam int NCH = 4;
  localparam logic [3:0] ST1 = 4'b0001;
  localparam logic [3:0] ST2 = 4'b0010;
  localparam logic [3:0] ST3 = 4'b0100;
  localparam logic [3:0] ST4 = 4'b1000;

  logic stage_ok;
  assign stage_ok = (stage_i != 4'b0) && ((stage_i & (stage_i - 4'd1)) == 4'b0);

  // channel order: s1 set, s1 rst, s2 set, s2 rst
  logic [NCH-1:0] start_v, end_v, lvl;
  assign start_v = {s2_rst_start, s2_set_start, s1_rst_start, s1_set_start};
  assign end_v   = {s2_rst_end,   s2_set_end,   s1_rst_end,   s1_set_end};

  for (genvar c = 0; c < NCH; c++) begin : g_stretch
    always_ff @(posedge clk) begin
      if (!rst_n || !stage_ok) lvl[c] <= 1'b0;
      else if (end_v[c])       lvl[c] <= 1'b0;
      else if (start_v[c])     lvl[c] <= 1'b1;
    end
  end

  logic [SYNC_LEN-1:0] bsync;
  logic                bprev;
  logic                brise;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsync <= '0;
      bprev <= 1'b0;
    end else begin
      bsync <= {bsync[SYNC_LEN-2:0], bunch_in};
      bprev <= bsync[SYNC_LEN-1];
    end
  end
  assign brise = bsync[SYNC_LEN-1] & ~bprev;

  logic [3:0] stage_prev;
  logic [1:0] turn;
  logic       entry;
  assign entry = stage_i != stage_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_prev <= 4'b0;
      turn       <= 2'd0;
    end else begin
      stage_prev <= stage_i;
      if (entry || !stage_ok) turn <= 2'd0;
      else if (brise) begin
        case (stage_i)
          ST3:     turn <= {1'b0, ~turn[0]};
          ST4:     turn <= (turn == 2'd2) ? 2'd0 : turn + 2'd1;
          default: turn <= 2'd0;
        endcase
      end
    end
  end

  logic [1:0] sel;
  logic [4:0] grp;
  assign sel = entry ? 2'd0 : turn;
  assign grp = (sel == 2'd0) ? GRP_N : (sel == 2'd1) ? GRP_N1 : GRP_N2;

  logic [4:0] nset, nrst;
  always_comb begin
    case (stage_i)
      ST1: begin
        nset = {3'b0, lvl[2], lvl[0]};
        nrst = {3'b0, lvl[3], lvl[1]};
      end
      ST2: begin
        nset = {2'b0, {3{lvl[0]}}};
        nrst = {2'b0, {3{lvl[1]}}};
      end
      ST3, ST4: begin
        nset = grp & {5{lvl[0]}};
        nrst = grp & {5{lvl[1]}};
      end
      default: begin
        nset = 5'b0;
        nrst = 5'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_set <= 5'b0;
      cell_rst <= 5'b0;
    end else begin
      cell_set <= nset;
      cell_rst <= nrst;
    end
  end
endmodule

// File: rtl/gate_trigger_router_chk.sv
module gate_trigger_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] stage_i,
  input logic       s1_set_start,
  input logic       s1_set_end,
  input logic [4:0] cell_set,
  input logic [4:0] cell_rst
);
  p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$onehot(stage_i) |=> (cell_set == 5'b0) && (cell_rst == 5'b0));

  p_series_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stage_i == 4'b0001 |=> (cell_set[4:2] == 3'b0) && (cell_rst[4:2] == 3'b0));

  p_parallel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stage_i == 4'b0010 |=> (cell_set[0] == cell_set[1]) && (cell_set[1] == cell_set[2])
                           && (cell_set[4:3] == 2'b0) && (cell_rst[4:3] == 2'b0));

  p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stage_i == 4'b0100 |=> (cell_set[2] == 1'b0) && (cell_set[0] == cell_set[3])
                           && (cell_set[1] == cell_set[4]) && !(cell_set[0] && cell_set[1]));

  p_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stage_i == 4'b1000 |=> !(cell_set[0] && cell_set[1]) && !(cell_set[2] && cell_set[3])
                           && ($countones(cell_set) != 1));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_i == 4'b0100) && ($past(stage_i) != 4'b0100)
      |=> (cell_set[1] == 1'b0) && (cell_set[4] == 1'b0));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_i == 4'b0001 && s1_set_start && !s1_set_end) ##1 (stage_i == 4'b0001)
      |=> cell_set[0]);
endmodule

bind gate_trigger_router gate_trigger_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stage_i(stage_i),
  .s1_set_start(s1_set_start), .s1_set_end(s1_set_end),
  .cell_set(cell_set), .cell_rst(cell_rst)
);

// File: tb/gate_trigger_router_test.sv
module gate_trigger_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bunch_in = 1'b0;
  logic [3:0] stage_i = 4'b0;
  logic [7:0] strb = 8'h00;
  logic [4:0] cell_set, cell_rst;

  always #2 clk = ~clk;

  gate_trigger_router uut (
    .clk(clk), .rst_n(rst_n), .bunch_in(bunch_in), .stage_i(stage_i),
    .s1_set_start(strb[0]), .s1_set_end(strb[1]),
    .s1_rst_start(strb[2]), .s1_rst_end(strb[3]),
    .s2_set_start(strb[4]), .s2_set_end(strb[5]),
    .s2_rst_start(strb[6]), .s2_rst_end(strb[7]),
    .cell_set(cell_set), .cell_rst(cell_rst)
  );

  typedef struct {
    string      tag;
    logic [4:0] s;
    logic [4:0] r;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk({it.tag, " set"}, cell_set, it.s);
        chk({it.tag, " rst"}, cell_rst, it.r);
      end
    end
  end

  task automatic expect_out(input string tag, input logic [4:0] s, input logic [4:0] r);
    item_t it;
    repeat (3) @(negedge clk);
    it.tag = tag; it.s = s; it.r = r;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic strobe(input logic [7:0] m);
    @(negedge clk) strb = m;
    @(negedge clk) strb = 8'h00;
  endtask

  task automatic turn_pulse(input int hold);
    @(negedge clk) bunch_in = 1'b1;
    repeat (hold) @(negedge clk);
    bunch_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_stage(input logic [3:0] st);
    @(negedge clk) stage_i = st;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    expect_out("R11 reset", 5'b0, 5'b0);

    strobe(8'h01);
    expect_out("R7 no stage blocks", 5'b0, 5'b0);
    set_stage(4'b0001);
    expect_out("R7 start ignored in guard", 5'b0, 5'b0);

    strobe(8'h01);
    expect_out("R3 src1 set to cell1", 5'b00001, 5'b0);
    strobe(8'h10);
    expect_out("R3 src2 set to cell2", 5'b00011, 5'b0);
    strobe(8'h04);
    expect_out("R3 src1 rst to cell1", 5'b00011, 5'b00001);
    strobe(8'h40);
    expect_out("R3 src2 rst to cell2", 5'b00011, 5'b00011);
    strobe(8'h02);
    expect_out("R1 end strobe drops level", 5'b00010, 5'b00011);
    strobe(8'h20);
    strobe(8'h88);
    expect_out("R1 all ends", 5'b0, 5'b0);

    // R10 cycle-exact latency
    @(negedge clk) strb = 8'h01;
    @(negedge clk) strb = 8'h00;
    chk("R10 one clock after strobe", cell_set, 5'b0);
    @(negedge clk);
    chk("R10 two clocks after strobe", cell_set, 5'b00001);
    strobe(8'h02);
    expect_out("R1 cleared again", 5'b0, 5'b0);

    strobe(8'h03);
    expect_out("R2 same-cycle from low", 5'b0, 5'b0);
    strobe(8'h01);
    strobe(8'h03);
    expect_out("R2 same-cycle from high", 5'b0, 5'b0);

    set_stage(4'b0010);
    strobe(8'h01);
    expect_out("R4 parallel set", 5'b00111, 5'b0);
    strobe(8'h10);
    strobe(8'h40);
    expect_out("R4 src2 ignored", 5'b00111, 5'b0);
    strobe(8'h04);
    expect_out("R4 parallel rst", 5'b00111, 5'b00111);
    strobe(8'h08);

    set_stage(4'b0100);
    expect_out("R8 stage III starts at N", 5'b01001, 5'b0);
    turn_pulse(2);
    expect_out("R5 turn to N+1", 5'b10010, 5'b0);
    turn_pulse(2);
    expect_out("R5 turn back to N", 5'b01001, 5'b0);
    turn_pulse(12);
    expect_out("R9 held pulse advances once", 5'b10010, 5'b0);

    set_stage(4'b1000);
    expect_out("R8 stage IV starts at N", 5'b01001, 5'b0);
    turn_pulse(2);
    expect_out("R6 second group", 5'b10010, 5'b0);
    turn_pulse(2);
    expect_out("R6 third group", 5'b10100, 5'b0);
    turn_pulse(2);
    expect_out("R6 wraps to N", 5'b01001, 5'b0);

    set_stage(4'b1100);
    expect_out("R7 multi-hot stage blocks", 5'b0, 5'b0);
    set_stage(4'b1000);
    expect_out("R7 stretcher cleared by guard", 5'b0, 5'b0);

    finish_run();
  end
endmodule